// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between an analog-to-digital converter core and the device pins. Once per converter period it takes a 12-bit result and drives it onto a 12-bit output bus. The bus can carry the whole word at once. It can also carry the word as a sequence of narrower pieces (8 then 4 bits, 6 then 6 bits, or three 4-bit pieces), one piece per master clock cycle, with the most significant piece first. The word can be complemented before output. It can also be held back by zero to three converter periods.

The converter period is two master clocks in the full-width, 8+4 and 6+6 formats and three master clocks in the 4+4+4 format. The block keeps its own phase counter, and the last phase of each period is the sample boundary. In the boundary cycle the block samples the result, its valid strobe and the configuration bits. A phase output tells the receiver which piece is on the bus.

Top module: `adc_out_fmt`

## Requirements
- R1: While reset is asserted, out_bus, out_phase and out_vld are all zero. After reset the active configuration is full-width format, no inversion and zero added latency.
- R2: out_phase counts 0,1,0,1… in formats 00, 01 and 10, and 0,1,2,0,… in format 11. The cycle in which out_phase holds its last value is the sample boundary.
- R3: Format 00 shows the whole 12-bit word on out_bus in every phase of its period.
- R4: Format 01 shows word bits 11:4 on out_bus[7:0] in phase 0 and word bits 3:0 on out_bus[3:0] in phase 1. All other bus bits are zero.
- R5: Format 10 shows word bits 11:6 in phase 0 and bits 5:0 in phase 1, both on out_bus[5:0]. All other bus bits are zero.
- R6: Format 11 shows word bits 11:8, 7:4 and 3:0 in phases 0, 1 and 2, each on out_bus[3:0]. Bits 11:4 are zero.
- R7: When the invert bit sampled at a boundary is 1, the word that starts after that boundary is the bitwise complement of the selected sample.
- R8: With delay code d, the sample taken at a boundary is shown in the period that starts d periods after the one right after that boundary. Its first piece is on the bus in the cycle after the boundary when d is 0.
- R9: smp_data, smp_vld, cfg_fmt, cfg_inv and cfg_dly are ignored outside the boundary cycle, and the active configuration cannot change within a period.
- R10: When the selected sample was taken with smp_vld low, out_vld is 0 and out_bus is all zero for that whole period, whatever the invert setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample-valid strobe, sampled at the boundary |
| smp_data | input | 12 | Conversion result, sampled at the boundary |
| cfg_fmt | input | 2 | Output format: 00 full, 01 8+4, 10 6+6, 11 4+4+4 |
| cfg_inv | input | 1 | Complement the output word |
| cfg_dly | input | 2 | Added latency in converter periods (0 to 3) |
| out_bus | output | 12 | Formatted data bus |
| out_phase | output | 2 | Index of the piece on the bus |
| out_vld | output | 1 | The word on the bus comes from a valid sample |

## Verification
The format, the invert bit and the delay selection can all change at the same boundary where a new sample is taken. When that happens, the word leaving the history tap must be complemented and split using the new settings, while the history itself shifts in the raw sample. The bench provokes this by changing format, inversion and delay together from one period to the next. It then compares every piece against a word it selects from its own copy of the sample history. During the middle of each period it drives complemented junk on every input, so a design that samples outside the boundary yields a wrong piece.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int SMP_W   = 12;
  localparam int PH_W    = 2;
  localparam int DLY_W   = 2;
  localparam int MAX_DLY = 3;

  typedef enum logic [1:0] {
    FMT_FULL  = 2'b00,
    FMT_8_4   = 2'b01,
    FMT_6_6   = 2'b10,
    FMT_4_4_4 = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e             fmt;
    logic             inv;
    logic [DLY_W-1:0] dly;
  } cfg_t;

  // last phase index of a converter period for a format
  function automatic logic [PH_W-1:0] last_phase(fmt_e f);
    return (f == FMT_4_4_4) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [SMP_W-1:0] apply_inv(logic inv, logic [SMP_W-1:0] w);
    return inv ? ~w : w;
  endfunction

  // piece of the word shown in a given phase
  function automatic logic [SMP_W-1:0] slice(fmt_e f, logic [PH_W-1:0] ph,
                                             logic [SMP_W-1:0] w);
    logic [SMP_W-1:0] r;
    case (f)
      FMT_FULL: r = w;
      FMT_8_4:  r = (ph == 2'd0) ? {4'b0, w[11:4]} : {8'b0, w[3:0]};
      FMT_6_6:  r = (ph == 2'd0) ? {6'b0, w[11:6]} : {6'b0, w[5:0]};
      default: begin
        case (ph)
          2'd0:    r = {8'b0, w[11:8]};
          2'd1:    r = {8'b0, w[7:4]};
          default: r = {8'b0, w[3:0]};
        endcase
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/adc_fmt_timer.sv
module adc_fmt_timer
  import adc_fmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  fmt_e            fmt,
  output logic [PH_W-1:0] phase,
  output logic            boundary
);
  assign boundary = (phase == last_phase(fmt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= '0;
    else if (boundary) phase <= '0;
    else               phase <= phase + 1'b1;
  end
endmodule

// File: rtl/adc_fmt_delay.sv
module adc_fmt_delay
  import adc_fmt_pkg::*;
#(
  parameter int W     = SMP_W,
  parameter int DEPTH = MAX_DLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_vld,
  input  logic [W-1:0]     in_data,
  input  logic [DLY_W-1:0] sel,
  input  logic             inv,
  output logic             word_vld,
  output logic [W-1:0]     word
);
  logic [DEPTH-1:0]        h_vld;
  logic [DEPTH-1:0][W-1:0] h_dat;
  logic                    tap_vld;
  logic [W-1:0]            tap_dat;

  for (genvar k = 0; k < DEPTH; k++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h_vld[k] <= 1'b0;
        h_dat[k] <= '0;
      end else if (adv) begin
        if (k == 0) begin
          h_vld[k] <= in_vld;
          h_dat[k] <= in_data;
        end else begin
          h_vld[k] <= h_vld[k-1];
          h_dat[k] <= h_dat[k-1];
        end
      end
    end
  end

  always_comb begin
    tap_vld = in_vld;
    tap_dat = in_data;
    for (int k = 0; k < DEPTH; k++) begin
      if (sel == DLY_W'(k + 1)) begin
        tap_vld = h_vld[k];
        tap_dat = h_dat[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      word     <= '0;
    end else if (adv) begin
      word_vld <= tap_vld;
      word     <= tap_vld ? apply_inv(inv, tap_dat) : '0;
    end
  end
endmodule

// File: rtl/adc_fmt_slicer.sv
module adc_fmt_slicer
  import adc_fmt_pkg::*;
(
  input  fmt_e             fmt,
  input  logic [PH_W-1:0]  phase,
  input  logic             word_vld,
  input  logic [SMP_W-1:0] word,
  output logic [SMP_W-1:0] bus
);
  assign bus = word_vld ? slice(fmt, phase, word) : '0;
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
(
  input  logic        mclk,
  input  logic        rst_n,
  input  logic        smp_vld,
  input  logic [11:0] smp_data,
  input  logic [1:0]  cfg_fmt,
  input  logic        cfg_inv,
  input  logic [1:0]  cfg_dly,
  output logic [11:0] out_bus,
  output logic [1:0]  out_phase,
  output logic        out_vld
);
  cfg_t             act;
  logic [PH_W-1:0]  phase;
  logic             boundary;
  logic             word_vld;
  logic [SMP_W-1:0] word;
  logic [1:0]       act_fmt_w;
  logic             act_inv_w;
  logic [1:0]       act_dly_w;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)        act <= '{fmt: FMT_FULL, inv: 1'b0, dly: '0};
    else if (boundary) act <= '{fmt: fmt_e'(cfg_fmt), inv: cfg_inv, dly: cfg_dly};
  end

  assign act_fmt_w = act.fmt;
  assign act_inv_w = act.inv;
  assign act_dly_w = act.dly;

  adc_fmt_timer u_timer (
    .clk      (mclk),
    .rst_n    (rst_n),
    .fmt      (act.fmt),
    .phase    (phase),
    .boundary (boundary)
  );

  adc_fmt_delay #(.W(SMP_W), .DEPTH(MAX_DLY)) u_delay (
    .clk      (mclk),
    .rst_n    (rst_n),
    .adv      (boundary),
    .in_vld   (smp_vld),
    .in_data  (smp_data),
    .sel      (cfg_dly),
    .inv      (cfg_inv),
    .word_vld (word_vld),
    .word     (word)
  );

  adc_fmt_slicer u_slicer (
    .fmt      (act.fmt),
    .phase    (phase),
    .word_vld (word_vld),
    .word     (word),
    .bus      (out_bus)
  );

  assign out_phase = phase;
  assign out_vld   = word_vld;
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic [1:0]  phase,
  input logic [1:0]  act_fmt,
  input logic        act_inv,
  input logic [1:0]  act_dly,
  input logic        smp_vld,
  input logic [1:0]  cfg_dly,
  input logic        out_vld,
  input logic [11:0] out_bus
);
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fmt == 2'b11) ? (phase <= 2'd2) : (phase <= 2'd1));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> phase == $past(phase) + 2'd1);

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> phase == 2'd0);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_fmt) && $stable(act_inv) && $stable(act_dly)));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> out_bus == 12'd0);

  assert_narrow_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_fmt == 2'b11 |-> out_bus[11:4] == 8'd0);

  assert_no_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && smp_vld && cfg_dly == 2'd0) |=> out_vld);
endmodule

bind adc_out_fmt adc_out_fmt_chk u_chk (
  .clk      (mclk),
  .rst_n    (rst_n),
  .boundary (boundary),
  .phase    (phase),
  .act_fmt  (act_fmt_w),
  .act_inv  (act_inv_w),
  .act_dly  (act_dly_w),
  .smp_vld  (smp_vld),
  .cfg_dly  (cfg_dly),
  .out_vld  (out_vld),
  .out_bus  (out_bus)
);

// File: tb/test_adc_out_fmt.sv
`timescale 1ns/1ps
module test_adc_out_fmt;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_data = '0;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_inv = 1'b0;
  logic [1:0]  cfg_dly = '0;
  logic [11:0] out_bus;
  logic [1:0]  out_phase;
  logic        out_vld;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic        bh_v [3];
  logic [11:0] bh_d [3];

  always #4 mclk = ~mclk;

  adc_out_fmt i_adc_out_fmt (
    .mclk(mclk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .cfg_fmt(cfg_fmt), .cfg_inv(cfg_inv), .cfg_dly(cfg_dly),
    .out_bus(out_bus), .out_phase(out_phase), .out_vld(out_vld)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Called at a negedge inside the boundary cycle; returns at the next one.
  task automatic do_period(logic [1:0] fmt, logic inv, logic [1:0] dly,
                           logic vld, logic [11:0] data, string req);
    logic        ev;
    logic [11:0] ed, ep;
    int          nph;
    cfg_fmt = fmt; cfg_inv = inv; cfg_dly = dly; smp_vld = vld; smp_data = data;
    if (dly == 2'd0) begin ev = vld; ed = data; end
    else begin ev = bh_v[dly-1]; ed = bh_d[dly-1]; end
    bh_v[2] = bh_v[1]; bh_d[2] = bh_d[1];
    bh_v[1] = bh_v[0]; bh_d[1] = bh_d[0];
    bh_v[0] = vld;     bh_d[0] = data;
    if (!ev) ed = '0;
    else if (inv) ed = ed ^ 12'hFFF;
    nph = (fmt == 2'b11) ? 3 : 2;
    for (int p = 0; p < nph; p++) begin
      @(negedge mclk);
      if (p == 0) begin // junk outside the boundary (R9)
        smp_data = ~data; smp_vld = ~vld; cfg_fmt = ~fmt; cfg_inv = ~inv; cfg_dly = ~dly;
      end
      case (fmt)
        2'b00: ep = ed;
        2'b01: ep = (p == 0) ? (ed >> 4) : (ed & 12'h00F);
        2'b10: ep = (p == 0) ? (ed >> 6) : (ed & 12'h03F);
        default: ep = (ed >> (4 * (2 - p))) & 12'h00F;
      endcase
      check(out_bus == ep, req, out_bus, ep);
      check(out_phase == 2'(p), "R2 phase", out_phase, p);
      check(out_vld == ev, {req, " R10 vld"}, out_vld, ev);
    end
  endtask

  task automatic t_reset;
    check(out_bus == 12'd0, "R1 bus", out_bus, 0);
    check(out_phase == 2'd0, "R1 phase", out_phase, 0);
    check(out_vld == 1'b0, "R1 vld", out_vld, 0);
    @(negedge mclk); rst_n = 1'b1;
    @(negedge mclk);
    check(out_phase == 2'd1, "R1 default ratio", out_phase, 1);
  endtask

  task automatic t_full;
    do_period(2'b00, 0, 0, 1, 12'hA5C, "R3");
    do_period(2'b00, 0, 0, 1, 12'hFFF, "R3");
    do_period(2'b00, 0, 0, 1, 12'h001, "R3");
  endtask

  task automatic t_split;
    do_period(2'b01, 0, 0, 1, 12'h9C3, "R4");
    do_period(2'b01, 0, 0, 1, 12'h0F0, "R4");
    do_period(2'b10, 0, 0, 1, 12'hB6D, "R5");
    do_period(2'b10, 0, 0, 1, 12'h03F, "R5");
    do_period(2'b11, 0, 0, 1, 12'h7E2, "R6");
    do_period(2'b11, 0, 0, 1, 12'h1A9, "R6");
  endtask

  task automatic t_invert;
    do_period(2'b00, 1, 0, 1, 12'h123, "R7");
    do_period(2'b11, 1, 0, 1, 12'hF0A, "R7");
    do_period(2'b01, 0, 0, 1, 12'h456, "R7 off");
  endtask

  task automatic t_delay;
    for (int i = 0; i < 4; i++) do_period(2'b00, 0, 2'd1, 1, 12'(12'h210 + i), "R8 d1");
    for (int i = 0; i < 4; i++) do_period(2'b10, 0, 2'd2, 1, 12'(12'h520 + 3*i), "R8 d2");
    for (int i = 0; i < 5; i++) do_period(2'b11, 0, 2'd3, 1, 12'(12'hC30 + 7*i), "R8 d3");
  endtask

  task automatic t_invalid;
    do_period(2'b00, 1, 0, 0, 12'hABC, "R10");
    do_period(2'b11, 1, 0, 0, 12'h555, "R10");
    do_period(2'b01, 0, 2'd2, 1, 12'h321, "R10 delayed");
  endtask

  task automatic t_switch;
    do_period(2'b11, 1, 2'd1, 1, 12'h8E1, "R9 switch");
    do_period(2'b00, 0, 2'd3, 1, 12'h4D2, "R9 switch");
    do_period(2'b10, 1, 2'd0, 1, 12'h2C3, "R9 switch");
    do_period(2'b01, 1, 2'd2, 0, 12'h6B4, "R9 switch");
    do_period(2'b11, 0, 2'd1, 1, 12'h3A5, "R9 switch");
  endtask

  always @(posedge mclk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin bh_v[k] = 1'b0; bh_d[k] = '0; end
    #1;
    t_reset();
    t_full();
    t_split();
    t_invert();
    t_delay();
    t_invalid();
    t_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule